// File: doc/BRIEF.md
# E1 Two-Frame Receive Slip Buffer

This block is a dual-clock elastic store for a 32-channel E1 receive path. Channel bytes arrive on the clock recovered from the line. Each byte carries its channel number, and channel 0 marks the start of a frame. The store holds two whole frames. The system side reads it on its own clock, driven by the system's channel counter, so received data is handed across to local timing without any flow control in either direction.

When the two clocks are locked, the read position trails the write position by a fixed amount and nothing else happens. When line wander pushes the writer too far ahead, the reader skips one whole frame at its next frame boundary. When the writer falls too far behind, the reader reads the frame it has just read a second time. Either correction flips a status bit, records which kind of slip it was, and raises a one-cycle interrupt pulse unless the interrupt is masked. Output frames always stay whole and channel-aligned.

The writer's position crosses into the system clock domain in Gray code. At each read-side frame boundary the block measures the occupancy, meaning how far the writer is ahead of the next frame to be read. A slip is taken only when that occupancy falls outside the window from `SLIP_LO` to `SLIP_HI`, with defaults of 1 and 58 bytes. The nominal occupancy is 32 bytes.

Top module: `e1_slip_buffer`

## Requirements
- R1: Reset clears the status outputs: `slip_tgl` = 0, `slip_dir` = 0 and `slip_irq` = 0. This also holds when a slip was recorded before the reset.
- R2: After reset the reader starts one frame behind the writer. If both counters start together, the byte read on channel c in read frame n+1 is the one written on channel c in write frame n. Read frame 0 returns stale contents.
- R3: `rd_data` presents the byte for a read request one `rd_clk` cycle after that request. The byte read on channel c is always a byte that was written with channel tag c.
- R4: Every output frame is whole: all 32 bytes read between two read-side frame boundaries come from a single received frame.
- R5: With the two clocks locked at the same rate, no slip ever occurs. Consecutive output frames carry consecutive received frames.
- R6: A fixed offset of 26 channel times between writer and reader, in either direction from nominal, causes no slip.
- R7: Overflow (the writer gains on the reader) is corrected by discarding exactly one whole received frame. `slip_dir` then reads 0.
- R8: Underflow (the reader gains on the writer) is corrected by reading exactly one whole frame a second time. `slip_dir` then reads 1.
- R9: `slip_tgl` changes state once per slip in either direction. `slip_dir` changes only together with `slip_tgl` and holds its value between slips.
- R10: Each slip produces a one-cycle `slip_irq` pulse when `irq_mask` is 0. When `irq_mask` is 1 there is no pulse, but the slip is still taken and still flips `slip_tgl`.
- R11: A slip is decided only on the read of the last channel (channel 31) of a frame. `slip_tgl` and `slip_irq` never change in response to any other read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Clock recovered from the received line |
| rst_n | input | 1 | Active-low reset, synchronous to each clock; hold it low for several cycles of both clocks |
| wr_en | input | 1 | A received byte is present this `wr_clk` cycle |
| wr_chan | input | 5 | Channel number of the received byte; 0 starts a frame |
| wr_data | input | 8 | Received channel byte |
| rd_clk | input | 1 | System clock |
| rd_en | input | 1 | The system reads a byte this cycle |
| rd_chan | input | 5 | System channel counter; reading channel 31 ends a frame |
| irq_mask | input | 1 | 1 suppresses the slip interrupt pulse |
| rd_data | output | 8 | Byte read, valid one `rd_clk` cycle after the request |
| slip_tgl | output | 1 | Changes state on every slip |
| slip_dir | output | 1 | Kind of the last slip: 0 = frame discarded, 1 = frame repeated |
| slip_irq | output | 1 | One-cycle pulse per unmasked slip |

## Verification
Read data is due on the first rising `rd_clk` edge after the request, so the bench drives each request on a falling edge and reads the previous request's byte on the next falling edge. Status and interrupt changes appear on that same rising edge, and only when it accepts a channel-31 read; the bench therefore tags every status change it observes with the channel whose read produced it. The occupancy that decides a slip lags the writer by two to three system cycles because of the synchronizer. For that reason the wander scenarios do not predict the exact frame of the slip. Instead they count frame-tag steps of 0, 1 and 2 across the whole run and check the status outputs afterwards.

// File: rtl/e1sb_pkg.sv
// Shared types for the E1 slip buffer.
// Assumes: nothing beyond the standard language.
package e1sb_pkg;

    // Which correction the last slip applied.
    typedef enum logic {
        SLIP_FRAME_LOST   = 1'b0,
        SLIP_FRAME_REPEAT = 1'b1
    } slip_kind_e;

    // Status bundle produced by the read-side controller.
    typedef struct packed {
        logic       toggle;
        slip_kind_e kind;
        logic       irq;
    } slip_status_t;

endpackage

// File: rtl/e1sb_wr_ptr.sv
// Write-side pointer of the slip buffer.
// Builds the store address from the current frame half and the channel tag.
// Steps a binary write pointer and a registered Gray copy of it on every
// accepted byte.
// Assumes: CHANS is a power of two, and channel tags arrive in order,
// wrapping from CHANS-1 to 0.
module e1sb_wr_ptr #(
    parameter int CHANS = 32,
    localparam int CH_W  = $clog2(CHANS),
    localparam int PTR_W = CH_W + 1
) (
    input  logic             wr_clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CH_W-1:0]  wr_chan,
    output logic [PTR_W-1:0] wr_addr,
    output logic [PTR_W-1:0] wr_gray
);

    logic [PTR_W-1:0] wptr;
    logic [PTR_W-1:0] wnext;

    // Frame half comes from the pointer; the channel comes from the byte's tag.
    assign wr_addr = {wptr[PTR_W-1], wr_chan};
    assign wnext   = PTR_W'(wr_addr + 1'b1);

    // Advance the binary pointer and its Gray image on each written byte.
    always_ff @(posedge wr_clk) begin
        if (!rst_n) begin
            wptr    <= '0;
            wr_gray <= '0;
        end else if (wr_en) begin
            wptr    <= wnext;
            wr_gray <= wnext ^ (wnext >> 1);
        end
    end

endmodule

// File: rtl/e1sb_sync.sv
// Multi-stage synchronizer for a Gray-coded pointer.
// The number of stages is a parameter.
// Assumes: the input changes by at most one bit between edges of the source
// clock.
module e1sb_sync #(
    parameter int W      = 6,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            // First stage samples the foreign-domain value.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[i] <= '0;
                else        stg[i] <= d;
            end
        end else begin : g_next
            // Later stages let metastability settle.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[i] <= '0;
                else        stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/e1sb_store.sv
// Two-frame byte store.
// Writes happen on the recovered clock; reads happen on the system clock,
// with one registered read stage.
// Assumes: the two ports may address the same location in unrelated cycles.
// The slip control keeps them a frame apart in normal use.
module e1sb_store #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 6,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              wr_clk,
    input  logic              wr_we,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] mem [DEPTH];

    // Capture an incoming channel byte.
    always_ff @(posedge wr_clk) begin
        if (wr_we) mem[wr_addr] <= wr_data;
    end

    // Present the requested byte one system cycle later.
    always_ff @(posedge rd_clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= mem[rd_addr];
    end

endmodule

// File: rtl/e1sb_rd_ctrl.sv
// Read-side frame selection and slip control.
// On the read of the last channel it measures how far the synchronized
// writer is ahead of the next frame to be read. Normally the reader then
// moves to the other half. When the occupancy leaves [SLIP_LO, SLIP_HI] the
// reader stays on the same half, which drops a frame on overflow and repeats
// one on underflow. The slip is reported in the status bundle.
// Assumes: the system channel counter runs 0..CHANS-1 in order, and the
// wander is slow compared with one frame.
module e1sb_rd_ctrl
    import e1sb_pkg::*;
#(
    parameter int CHANS   = 32,
    parameter int SLIP_LO = 1,
    parameter int SLIP_HI = 58,
    localparam int CH_W  = $clog2(CHANS),
    localparam int PTR_W = CH_W + 1
) (
    input  logic             rd_clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic [CH_W-1:0]  rd_chan,
    input  logic             irq_mask,
    input  logic [PTR_W-1:0] wsync_gray,
    output logic [PTR_W-1:0] rd_addr,
    output slip_status_t     status
);

    localparam logic [PTR_W-1:0] LO_P  = PTR_W'(SLIP_LO);
    localparam logic [PTR_W-1:0] HI_P  = PTR_W'(SLIP_HI);
    localparam logic [CH_W-1:0]  LAST  = CH_W'(CHANS - 1);

    logic             rfrm;
    logic [PTR_W-1:0] wbin;
    logic [PTR_W-1:0] occ;
    logic             at_end;
    logic             under_f;
    logic             over_f;

    // Convert the synchronized Gray pointer back to binary.
    function automatic logic [PTR_W-1:0] gray_to_bin(input logic [PTR_W-1:0] g);
        logic [PTR_W-1:0] b;
        b[PTR_W-1] = g[PTR_W-1];
        for (int i = PTR_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    // Occupancy measured against the start of the half that would be read next.
    always_comb begin
        wbin    = gray_to_bin(wsync_gray);
        occ     = wbin - {~rfrm, {CH_W{1'b0}}};
        at_end  = rd_en && (rd_chan == LAST);
        under_f = (occ < LO_P);
        over_f  = (occ > HI_P);
    end

    assign rd_addr = {rfrm, rd_chan};

    // Choose the next frame half and record any slip at the frame boundary.
    always_ff @(posedge rd_clk) begin
        if (!rst_n) begin
            rfrm          <= 1'b1;
            status.toggle <= 1'b0;
            status.kind   <= SLIP_FRAME_LOST;
            status.irq    <= 1'b0;
        end else begin
            status.irq <= 1'b0;
            if (at_end) begin
                if (under_f || over_f) begin
                    status.toggle <= ~status.toggle;
                    status.kind   <= under_f ? SLIP_FRAME_REPEAT : SLIP_FRAME_LOST;
                    status.irq    <= ~irq_mask;
                end else begin
                    rfrm <= ~rfrm;
                end
            end
        end
    end

endmodule

// File: rtl/e1_slip_buffer.sv
// Top level of the E1 two-frame receive slip buffer.
// Connects the write pointer, the Gray synchronizer, the byte store and the
// read-side slip control.
// Assumes: rst_n is held low for several cycles of both clocks.
module e1_slip_buffer
    import e1sb_pkg::*;
#(
    parameter int CHANS       = 32,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int SLIP_LO     = 1,
    parameter int SLIP_HI     = 58,
    localparam int CH_W  = $clog2(CHANS),
    localparam int PTR_W = CH_W + 1
) (
    input  logic              wr_clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CH_W-1:0]   wr_chan,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_clk,
    input  logic              rd_en,
    input  logic [CH_W-1:0]   rd_chan,
    input  logic              irq_mask,
    output logic [DATA_W-1:0] rd_data,
    output logic              slip_tgl,
    output logic              slip_dir,
    output logic              slip_irq
);

    logic [PTR_W-1:0] wr_addr;
    logic [PTR_W-1:0] wr_gray;
    logic [PTR_W-1:0] wsync_gray;
    logic [PTR_W-1:0] rd_addr;
    slip_status_t     stat;

    e1sb_wr_ptr #(.CHANS(CHANS)) wr_ptr_i (
        .wr_clk  (wr_clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_chan (wr_chan),
        .wr_addr (wr_addr),
        .wr_gray (wr_gray)
    );

    e1sb_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) sync_i (
        .clk   (rd_clk),
        .rst_n (rst_n),
        .d     (wr_gray),
        .q     (wsync_gray)
    );

    e1sb_store #(.DATA_W(DATA_W), .ADDR_W(PTR_W)) store_i (
        .wr_clk  (wr_clk),
        .wr_we   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_clk  (rd_clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    e1sb_rd_ctrl #(.CHANS(CHANS), .SLIP_LO(SLIP_LO), .SLIP_HI(SLIP_HI)) rd_ctrl_i (
        .rd_clk     (rd_clk),
        .rst_n      (rst_n),
        .rd_en      (rd_en),
        .rd_chan    (rd_chan),
        .irq_mask   (irq_mask),
        .wsync_gray (wsync_gray),
        .rd_addr    (rd_addr),
        .status     (stat)
    );

    assign slip_tgl = stat.toggle;
    assign slip_dir = stat.kind;
    assign slip_irq = stat.irq;

endmodule

// File: rtl/e1sb_checker.sv
// Temporal checks on the slip buffer's status outputs and its Gray write
// pointer. Attached to the top module through the bind below.
module e1sb_checker #(
    parameter int CHANS = 32,
    parameter int PTR_W = 6,
    localparam int CH_W = $clog2(CHANS)
) (
    input logic             rd_clk,
    input logic             wr_clk,
    input logic             rst_n,
    input logic             rd_en,
    input logic [CH_W-1:0]  rd_chan,
    input logic             irq_mask,
    input logic             slip_tgl,
    input logic             slip_dir,
    input logic             slip_irq,
    input logic [PTR_W-1:0] wr_gray
);

    // R1: status is clear in the first cycle after reset.
    assert_reset_clear_R1: assert property (@(posedge rd_clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!slip_tgl && !slip_dir && !slip_irq));

    // R11: the toggle moves only after a last-channel read.
    assert_tgl_at_boundary_R11: assert property (@(posedge rd_clk) disable iff (!rst_n)
        !$stable(slip_tgl) |-> $past(rd_en && (rd_chan == CH_W'(CHANS - 1))));

    // R9: the direction flag never moves without the toggle.
    assert_dir_with_tgl_R9: assert property (@(posedge rd_clk) disable iff (!rst_n)
        !$stable(slip_dir) |-> !$stable(slip_tgl));

    // R10: an unmasked slip raises the interrupt pulse.
    assert_irq_on_slip_R10: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (!$stable(slip_tgl) && !$past(irq_mask)) |-> slip_irq);

    // R10: the pulse appears only for an unmasked slip.
    assert_irq_only_unmasked_R10: assert property (@(posedge rd_clk) disable iff (!rst_n)
        slip_irq |-> (!$stable(slip_tgl) && !$past(irq_mask)));

    // R6: the crossing pointer steps by a single Gray bit per write clock.
    assert_gray_step_R6: assert property (@(posedge wr_clk) disable iff (!rst_n)
        $countones(wr_gray ^ $past(wr_gray)) <= 1);

endmodule

bind e1_slip_buffer e1sb_checker #(.CHANS(CHANS), .PTR_W(PTR_W)) chk_i (
    .rd_clk   (rd_clk),
    .wr_clk   (wr_clk),
    .rst_n    (rst_n),
    .rd_en    (rd_en),
    .rd_chan  (rd_chan),
    .irq_mask (irq_mask),
    .slip_tgl (slip_tgl),
    .slip_dir (slip_dir),
    .slip_irq (slip_irq),
    .wr_gray  (wr_gray)
);

// File: tb/e1_slip_buffer_tb_top.sv
`timescale 1ns/1ps
module e1_slip_buffer_tb_top;

    localparam int CHANS = 32;

    logic rd_clk = 1'b0;
    logic wr_clk = 1'b0;
    real  wr_half = 5.0;

    always #5 rd_clk = ~rd_clk;
    initial begin
        #1.3;
        forever #(wr_half) wr_clk = ~wr_clk;
    end

    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [4:0] wr_chan = '0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic [4:0] rd_chan = '0;
    logic       irq_mask = 1'b0;
    logic [7:0] rd_data;
    logic       slip_tgl, slip_dir, slip_irq;

    e1_slip_buffer dut_i (
        .wr_clk(wr_clk), .rst_n(rst_n), .wr_en(wr_en), .wr_chan(wr_chan),
        .wr_data(wr_data), .rd_clk(rd_clk), .rd_en(rd_en), .rd_chan(rd_chan),
        .irq_mask(irq_mask), .rd_data(rd_data), .slip_tgl(slip_tgl),
        .slip_dir(slip_dir), .slip_irq(slip_irq)
    );

    int  n_checks = 0;
    int  n_errs   = 0;
    bit  wr_stop  = 1'b0;
    bit  done     = 1'b0;

    // Per-run observations.
    int   first_tag, prev_tag;
    int   d0, d1, d2, dbad;
    int   align_err, whole_err, bound_err, dir_err;
    int   tgl_chg, irq_cnt;
    logic st_tgl, st_dir;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n   = 1'b0;
        wr_en   = 1'b0;
        rd_en   = 1'b0;
        wr_half = 5.0;
        repeat (6) @(negedge rd_clk);
        rst_n = 1'b1;
        @(negedge rd_clk);
    endtask

    task automatic wr_run();
        int f = 0;
        int c = 0;
        while (!wr_stop) begin
            @(negedge wr_clk);
            wr_en   = 1'b1;
            wr_chan = 5'(c);
            wr_data = {3'(f), 5'(c)};
            c++;
            if (c == CHANS) begin
                c = 0;
                f++;
            end
        end
        @(negedge wr_clk);
        wr_en = 1'b0;
    endtask

    // Inspect the byte and status produced for read request (n, c).
    task automatic observe(input int n, input int c);
        int tag;
        tag = int'(rd_data[7:5]);
        if (n >= 1) begin
            if (rd_data[4:0] != 5'(c)) align_err++;
            if (c == 0) begin
                if (n == 1) first_tag = tag;
                else begin
                    case ((tag - prev_tag) & 7)
                        0: d0++;
                        1: d1++;
                        2: d2++;
                        default: dbad++;
                    endcase
                end
                prev_tag = tag;
            end else if (tag != prev_tag) begin
                whole_err++;
            end
        end
        if (slip_tgl != st_tgl) begin
            tgl_chg++;
            if (c != CHANS - 1) bound_err++;
        end else if (slip_dir != st_dir) begin
            dir_err++;
        end
        if (slip_irq) begin
            irq_cnt++;
            if (c != CHANS - 1) bound_err++;
        end
        st_tgl = slip_tgl;
        st_dir = slip_dir;
    endtask

    task automatic rd_run(input int frames);
        int  pn = 0;
        int  pc = 0;
        bit  pend = 1'b0;
        st_tgl = slip_tgl;
        st_dir = slip_dir;
        for (int n = 0; n < frames; n++) begin
            for (int c = 0; c < CHANS; c++) begin
                @(negedge rd_clk);
                if (pend) observe(pn, pc);
                rd_en   = 1'b1;
                rd_chan = 5'(c);
                pend = 1'b1;
                pn = n;
                pc = c;
            end
        end
        @(negedge rd_clk);
        observe(pn, pc);
        rd_en   = 1'b0;
        wr_stop = 1'b1;
    endtask

    // Reset, then run writer and reader with the given clock and start offsets.
    task automatic run_case(input real half, input int wr_lag, input int rd_lag,
                            input int frames, input bit mask);
        first_tag = -1; prev_tag = 0;
        d0 = 0; d1 = 0; d2 = 0; dbad = 0;
        align_err = 0; whole_err = 0; bound_err = 0; dir_err = 0;
        tgl_chg = 0; irq_cnt = 0;
        irq_mask = mask;
        do_reset();
        wr_half = half;
        wr_stop = 1'b0;
        fork
            begin
                repeat (wr_lag) @(negedge rd_clk);
                wr_run();
            end
            begin
                repeat (rd_lag) @(negedge rd_clk);
                rd_run(frames);
            end
        join
        @(negedge rd_clk);
    endtask

    task automatic test_reset_state();
        do_reset();
        chk(slip_tgl == 1'b0, "R1", "slip_tgl after reset", int'(slip_tgl), 0);
        chk(slip_dir == 1'b0, "R1", "slip_dir after reset", int'(slip_dir), 0);
        chk(slip_irq == 1'b0, "R1", "slip_irq after reset", int'(slip_irq), 0);
    endtask

    task automatic test_locked();
        run_case(5.0, 0, 0, 40, 1'b0);
        chk(first_tag == 0, "R2", "tag of read frame 1", first_tag, 0);
        chk(align_err == 0, "R3", "channel misalignments", align_err, 0);
        chk(whole_err == 0, "R4", "torn frames", whole_err, 0);
        chk(tgl_chg == 0, "R5", "slips while locked", tgl_chg, 0);
        chk(d1 == 38, "R5", "consecutive frame steps", d1, 38);
        chk(irq_cnt == 0, "R10", "interrupts while locked", irq_cnt, 0);
    endtask

    task automatic test_offsets();
        // Reader 26 channel times late: occupancy near the high limit.
        run_case(5.0, 0, 26, 40, 1'b0);
        chk(tgl_chg == 0, "R6", "slips, reader late by 26", tgl_chg, 0);
        chk(d1 == 38, "R6", "frame steps, reader late by 26", d1, 38);
        chk(align_err == 0, "R3", "misalignments, reader late", align_err, 0);
        // Writer 26 channel times late: occupancy near the low limit.
        run_case(5.0, 26, 0, 40, 1'b0);
        chk(tgl_chg == 0, "R6", "slips, writer late by 26", tgl_chg, 0);
        chk(d1 == 38, "R6", "frame steps, writer late by 26", d1, 38);
        chk(whole_err == 0, "R4", "torn frames, writer late", whole_err, 0);
    endtask

    task automatic test_overflow();
        run_case(4.95, 0, 0, 150, 1'b0);
        chk(tgl_chg == 1, "R9", "toggle changes on overflow", tgl_chg, 1);
        chk(slip_tgl == 1'b1, "R9", "toggle level after one slip", int'(slip_tgl), 1);
        chk(d2 == 1, "R7", "frames dropped", d2, 1);
        chk(d0 == 0 && dbad == 0, "R7", "repeated or bad steps", d0 + dbad, 0);
        chk(slip_dir == 1'b0, "R7", "direction after overflow", int'(slip_dir), 0);
        chk(irq_cnt == 1, "R10", "interrupt pulses on overflow", irq_cnt, 1);
        chk(bound_err == 0, "R11", "status changes off boundary", bound_err, 0);
        chk(dir_err == 0, "R9", "direction moves without toggle", dir_err, 0);
        chk(whole_err == 0 && align_err == 0, "R4", "torn frames in overflow run",
            whole_err + align_err, 0);
    endtask

    task automatic test_underflow();
        run_case(5.05, 0, 0, 150, 1'b0);
        chk(tgl_chg == 1, "R9", "toggle changes on underflow", tgl_chg, 1);
        chk(d0 == 1, "R8", "frames repeated", d0, 1);
        chk(d2 == 0 && dbad == 0, "R8", "dropped or bad steps", d2 + dbad, 0);
        chk(slip_dir == 1'b1, "R8", "direction after underflow", int'(slip_dir), 1);
        chk(irq_cnt == 1, "R10", "interrupt pulses on underflow", irq_cnt, 1);
        chk(bound_err == 0, "R11", "status changes off boundary", bound_err, 0);
        chk(whole_err == 0 && align_err == 0, "R4", "torn frames in underflow run",
            whole_err + align_err, 0);
        // Reset after a recorded slip clears the status again.
        do_reset();
        chk(slip_tgl == 1'b0 && slip_dir == 1'b0, "R1", "status after reset following slip",
            int'({slip_tgl, slip_dir}), 0);
    endtask

    task automatic test_masked();
        run_case(5.05, 0, 0, 150, 1'b1);
        chk(tgl_chg == 1, "R10", "masked slip still toggles", tgl_chg, 1);
        chk(irq_cnt == 0, "R10", "masked interrupt pulses", irq_cnt, 0);
        chk(d0 == 1, "R8", "masked run frames repeated", d0, 1);
    endtask

    initial begin
        test_reset_state();
        test_locked();
        test_offsets();
        test_overflow();
        test_underflow();
        test_masked();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

    initial begin
        #1500000;
        if (!done) begin
            chk(1'b0, "all", "watchdog expired", 0, 1);
            $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
            $finish;
        end
    end

endmodule